// File: doc/BRIEF.md
# Reset Remote Terminal Mode Command Handler

This block sits behind the command decoder of a MIL-STD-1553 remote terminal. It watches for a validated "reset remote terminal" mode command, which is mode code 8 received with the transmit/receive bit set. When such a command is accepted, the block raises a one-cycle interrupt so the host can finish the reset. It also records that a reset is pending.

The cleanup does not run when the command arrives. The block holds it back until the encoder reports that the status word answering the command has gone out. At that point it pulses a set of clear strobes, all in the same cycle. The strobes drop the Message Error and Broadcast Command Received flags in the internal status word and clear three bits of the built-in-test word. They also lift any transmitter shutdown ordered by mode codes 4 or 20 and lift the terminal flag inhibit.

The block has no path into the host configuration registers, so those keep their values. Several accepted commands that arrive before the status word is sent collapse into one pending reset.

Top module: `rtmc_reset_handler`

## Requirements
- R1: A command strobe is accepted only when the code equals 8, the T/R bit is 1 and the invalid flag is 0. Any other strobe produces no interrupt and leaves no pending reset.
- R2: Each accepted command raises `irq_reset` for exactly the one cycle that follows the accepting clock edge.
- R3: No clear strobe is raised before the status-sent strobe is seen while a reset is pending. The clears appear in the cycle after that status-sent strobe.
- R4: The clear action pulses `clr_msg_err` and `clr_bcast_rx`.
- R5: During the clear action, `clr_bit_bits` equals 16'hC001, which selects BIT word bits 0, 14 and 15. Outside the clear action it is zero.
- R6: The clear action pulses `clr_tx_shut`, which cancels shutdowns from mode codes 4 and 20, and `clr_flag_inh`, which cancels the terminal flag inhibit.
- R7: Any number of accepted commands before a status-sent strobe leave one pending reset. That reset yields one clear action, and a later status-sent strobe yields none.
- R8: A status-sent strobe while no reset is pending produces no clear action.
- R9: While reset is active and right after it, every output is 0.
- R10: All clear outputs rise and fall together, and each clear action lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_stb | input | 1 | One-cycle strobe for a decoded mode command |
| mc_code | input | 5 | Mode code field of the command |
| mc_tr | input | 1 | T/R bit of the command |
| mc_bad | input | 1 | Command failed validation |
| sts_sent | input | 1 | One-cycle strobe: the status word has been transmitted |
| irq_reset | output | 1 | One-cycle interrupt to the host on an accepted command |
| clr_msg_err | output | 1 | Clear the Message Error status flag |
| clr_bcast_rx | output | 1 | Clear the Broadcast Command Received flag |
| clr_bit_bits | output | 16 | Mask of BIT word bits to clear |
| clr_tx_shut | output | 1 | Cancel transmitter shutdowns |
| clr_flag_inh | output | 1 | Cancel the terminal flag inhibit |

## Verification
The hardest cases to reach from the ports are the ones where a new valid command lands in the same cycle as the status-sent strobe, or arrives again while a reset is already pending. Only those cases show whether pending resets merge correctly and whether a reset re-armed in the same cycle survives. The random stimulus drives both strobes with high probability and biases the code toward 8, so these collisions occur often. Directed sequences also hit the back-to-back accept and the same-cycle cases explicitly.

// File: rtl/rtmc_pkg.sv
package rtmc_pkg;
    localparam int RTMC_CODE_W   = 5;
    localparam int RTMC_BIT_W    = 16;
    localparam int RTMC_RST_CODE = 8;

    typedef struct packed {
        logic msg_err;
        logic bcast;
        logic tx_shut;
        logic flag_inh;
    } rtmc_clr_t;
endpackage

// File: rtl/rtmc_decode.sv
module rtmc_decode #(
    parameter int CODE_W   = rtmc_pkg::RTMC_CODE_W,
    parameter int RST_CODE = rtmc_pkg::RTMC_RST_CODE
) (
    input  logic              stb,
    input  logic [CODE_W-1:0] code,
    input  logic              tr,
    input  logic              bad,
    output logic              accept
);
    localparam logic [CODE_W-1:0] MATCH = CODE_W'(RST_CODE);

    always_comb begin
        accept = stb && tr && !bad && (code == MATCH);
    end
endmodule

// File: rtl/rtmc_pend.sv
module rtmc_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic sts_sent,
    output logic irq,
    output logic fire
);
    typedef struct packed {
        logic irq;
        logic pend;
    } pend_state_t;

    pend_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        fire      = st_q.pend && sts_sent;
        st_d.irq  = accept;
        st_d.pend = (st_q.pend && !sts_sent) || accept;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/rtmc_clear.sv
module rtmc_clear
    import rtmc_pkg::*;
#(
    parameter int              BIT_W    = RTMC_BIT_W,
    parameter logic [BIT_W-1:0] BIT_MASK = BIT_W'(16'hC001)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    output rtmc_clr_t        flags,
    output logic [BIT_W-1:0] bits
);
    typedef struct packed {
        rtmc_clr_t        flags;
        logic [BIT_W-1:0] bits;
    } clr_state_t;

    clr_state_t st_d, st_q;

    always_comb begin
        st_d                = '0;
        st_d.flags.msg_err  = fire;
        st_d.flags.bcast    = fire;
        st_d.flags.tx_shut  = fire;
        st_d.flags.flag_inh = fire;
        st_d.bits           = fire ? BIT_MASK : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flags;
    assign bits  = st_q.bits;
endmodule

// File: rtl/rtmc_reset_handler.sv
module rtmc_reset_handler
    import rtmc_pkg::*;
#(
    parameter int CODE_W   = RTMC_CODE_W,
    parameter int BIT_W    = RTMC_BIT_W,
    parameter int RST_CODE = RTMC_RST_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_stb,
    input  logic [CODE_W-1:0] mc_code,
    input  logic              mc_tr,
    input  logic              mc_bad,
    input  logic              sts_sent,
    output logic              irq_reset,
    output logic              clr_msg_err,
    output logic              clr_bcast_rx,
    output logic [BIT_W-1:0]  clr_bit_bits,
    output logic              clr_tx_shut,
    output logic              clr_flag_inh
);
    localparam logic [BIT_W-1:0] BIT_CLR =
        BIT_W'(1) | (BIT_W'(1) << (BIT_W-2)) | (BIT_W'(1) << (BIT_W-1));

    logic      accept;
    logic      fire;
    rtmc_clr_t flags;

    rtmc_decode #(.CODE_W(CODE_W), .RST_CODE(RST_CODE)) u_dec (
        .stb(mc_stb), .code(mc_code), .tr(mc_tr), .bad(mc_bad), .accept(accept)
    );

    rtmc_pend u_pend (
        .clk(clk), .rst_n(rst_n), .accept(accept), .sts_sent(sts_sent),
        .irq(irq_reset), .fire(fire)
    );

    rtmc_clear #(.BIT_W(BIT_W), .BIT_MASK(BIT_CLR)) u_clr (
        .clk(clk), .rst_n(rst_n), .fire(fire), .flags(flags), .bits(clr_bit_bits)
    );

    assign clr_msg_err  = flags.msg_err;
    assign clr_bcast_rx = flags.bcast;
    assign clr_tx_shut  = flags.tx_shut;
    assign clr_flag_inh = flags.flag_inh;
endmodule

// File: rtl/rtmc_reset_handler_chk.sv
module rtmc_reset_handler_chk #(
    parameter int CODE_W = 5,
    parameter int BIT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mc_stb,
    input logic [CODE_W-1:0] mc_code,
    input logic              mc_tr,
    input logic              mc_bad,
    input logic              sts_sent,
    input logic              irq_reset,
    input logic              clr_msg_err,
    input logic              clr_bcast_rx,
    input logic [BIT_W-1:0]  clr_bit_bits,
    input logic              clr_tx_shut,
    input logic              clr_flag_inh
);
    logic good_cmd;
    assign good_cmd = mc_stb && mc_tr && !mc_bad && (mc_code == CODE_W'(8));

    AST_IRQ_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        good_cmd |=> irq_reset) else $error("irq missing"); // R2

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_reset |-> $past(good_cmd)) else $error("irq without cmd"); // R1

    AST_CLR_AFTER_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_msg_err |-> $past(sts_sent)) else $error("clear early"); // R3

    AST_CLR_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_bcast_rx == clr_msg_err) && (clr_tx_shut == clr_msg_err) &&
        (clr_flag_inh == clr_msg_err)) else $error("clear split"); // R10

    AST_BIT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        clr_bit_bits == (clr_msg_err ? BIT_W'(16'hC001) : '0)) else $error("mask"); // R5
endmodule

bind rtmc_reset_handler rtmc_reset_handler_chk #(.CODE_W(CODE_W), .BIT_W(BIT_W)) u_chk (.*);

// File: tb/rtmc_reset_handler_tb.sv
module rtmc_reset_handler_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mc_stb = 1'b0;
    logic [4:0]  mc_code = '0;
    logic        mc_tr = 1'b0;
    logic        mc_bad = 1'b0;
    logic        sts_sent = 1'b0;
    logic        irq_reset, clr_msg_err, clr_bcast_rx, clr_tx_shut, clr_flag_inh;
    logic [15:0] clr_bit_bits;

    int errors = 0;
    int checks = 0;
    bit m_pend = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtmc_reset_handler dut_i (
        .clk(clk), .rst_n(rst_n), .mc_stb(mc_stb), .mc_code(mc_code), .mc_tr(mc_tr),
        .mc_bad(mc_bad), .sts_sent(sts_sent), .irq_reset(irq_reset),
        .clr_msg_err(clr_msg_err), .clr_bcast_rx(clr_bcast_rx), .clr_bit_bits(clr_bit_bits),
        .clr_tx_shut(clr_tx_shut), .clr_flag_inh(clr_flag_inh)
    );

    function automatic bit exp_accept(bit s, logic [4:0] c, bit t, bit b);
        return s && t && !b && (c == 5'd8);
    endfunction

    function automatic logic [15:0] exp_mask(bit f);
        return f ? 16'hC001 : 16'h0000;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, let the edge pass, compare against the model.
    task automatic step(bit s, logic [4:0] c, bit t, bit b, bit ss, string tag);
        bit acc, fire;
        @(negedge clk);
        mc_stb = s; mc_code = c; mc_tr = t; mc_bad = b; sts_sent = ss;
        acc  = exp_accept(s, c, t, b);
        fire = m_pend && ss;
        m_pend = (m_pend && !ss) || acc;
        @(posedge clk);
        #1;
        chk({tag, " R1/R2 irq"}, 32'(irq_reset), 32'(acc));
        chk({tag, " R3/R4 me"}, 32'(clr_msg_err), 32'(fire));
        chk({tag, " R4 bcr"}, 32'(clr_bcast_rx), 32'(fire));
        chk({tag, " R5 bits"}, 32'(clr_bit_bits), 32'(exp_mask(fire)));
        chk({tag, " R6 shut"}, 32'(clr_tx_shut), 32'(fire));
        chk({tag, " R6 inh"}, 32'(clr_flag_inh), 32'(fire));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        chk("R9 irq", 32'(irq_reset), 0);
        chk("R9 clr", 32'({clr_msg_err, clr_bcast_rx, clr_tx_shut, clr_flag_inh}), 0);
        chk("R9 bits", 32'(clr_bit_bits), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: ignored commands, then a status strobe proves nothing pends (R8)
        step(1, 5'd8, 0, 0, 0, "R1 tr0");
        step(1, 5'd8, 1, 1, 0, "R1 bad");
        step(1, 5'd4, 1, 0, 0, "R1 code4");
        step(0, 5'd8, 1, 0, 0, "R1 nostb");
        step(0, 5'd0, 0, 0, 1, "R8 idle sts");
        // R2/R3: accept, wait, then status
        step(1, 5'd8, 1, 0, 0, "R2 accept");
        step(0, 5'd0, 0, 0, 0, "R3 wait");
        step(0, 5'd0, 0, 0, 1, "R3 sts");
        step(0, 5'd0, 0, 0, 0, "R10 one cycle");
        // R7: back-to-back accepts collapse
        step(1, 5'd8, 1, 0, 0, "R7 acc1");
        step(1, 5'd8, 1, 0, 0, "R7 acc2");
        step(0, 5'd0, 0, 0, 1, "R7 sts1");
        step(0, 5'd0, 0, 0, 1, "R7 sts2");
        // Same-cycle accept on top of a pending reset with status
        step(1, 5'd8, 1, 0, 0, "R7 arm");
        step(1, 5'd8, 1, 0, 1, "R7 rearm+sts");
        step(0, 5'd0, 0, 0, 1, "R7 second sts");
        // Same-cycle accept and status with nothing pending
        step(1, 5'd8, 1, 0, 1, "R3 same-cycle");
        step(0, 5'd0, 0, 0, 1, "R3 later sts");

        for (int i = 0; i < 3000; i++) begin
            logic [4:0] c;
            c = ($urandom % 3 == 0) ? 5'($urandom) : 5'd8;
            step(($urandom % 2) == 0, c, ($urandom % 4) != 0, ($urandom % 6) == 0,
                 ($urandom % 3) == 0, "rand");
        end

        // R9: reset in the middle of a pending reset
        step(1, 5'd8, 1, 0, 0, "R9 arm");
        @(negedge clk);
        rst_n = 1'b0;
        mc_stb = 0; sts_sent = 1;
        @(posedge clk);
        #1;
        chk("R9 mid irq", 32'(irq_reset), 0);
        chk("R9 mid clr", 32'(clr_msg_err), 0);
        @(negedge clk);
        rst_n = 1'b1;
        m_pend = 1'b0;
        step(0, 5'd0, 0, 0, 1, "R9 pend dropped");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule